// File: doc/BRIEF.md
# Dual-Role Power and Termination Controller

This block sits between the role and session control of a dual-role USB controller and the pins that reach the PHY and the external 5 V supply switch. Software picks host or device through a mode input and starts or ends a session with single-cycle pulses. The PHY reports whether VBUS is within its valid range. From these the block drives four outputs without any software sequencing: the enable of the external VBUS supply, the D+ pull-up and the two data-line pull-downs. It also reports which endpoint direction serves IN and OUT traffic for the current role.

The VBUS-valid status is asynchronous. It passes through a synchroniser chain and a debounce filter before it is used. In device role, a VBUS-valid status that stays high is what shows an attached host. When it is lost, the session ends and the D+ pull-up is removed. A role change is accepted only while no session is active. Each accepted role change forces one cycle in which every enable is low, so host and device terminations are never applied together. All outputs are registered.

Top module: `dualrole_pwr_ctl`

## Requirements
- R1: On a synchronous active-high reset the effective role is device, the session is inactive, all four enables are low, `in_uses_tx_o` is 1 and `out_uses_tx_o` is 0.
- R2: In host role, `vbus_drv_o` is high exactly while a session is active; a host with no session keeps it low.
- R3: In device role, `vbus_drv_o`, `dp_pulldn_o` and `dm_pulldn_o` are low.
- R4: In host role, outside the transition cycle, both pull-downs are high and `dp_pullup_o` is low.
- R5: In device role, `dp_pullup_o` is high only while the debounced VBUS-valid is high. It follows a debounced change one clock later.
- R6: A change of `phy_vbus_valid_i` that holds for DEB_LEN cycles or more reaches `dp_pullup_o` DEB_LEN+3 clock edges after its first sampling edge. A pulse shorter than DEB_LEN cycles has no effect.
- R7: In device role, the session is cleared when the debounced VBUS-valid is low. A start pulse in device role while VBUS is not valid leaves `session_o` at 0.
- R8: A change of `mode_host_i` (1 = host, 0 = device) while a session is active is ignored. It takes effect once the session has ended.
- R9: When the effective role changes, the cycle in which the new endpoint mapping first appears has all four enables low. A pull-up and a pull-down are never high together.
- R10: `in_uses_tx_o` is 1 and `out_uses_tx_o` is 0 in device role; in host role the values are swapped.
- R11: A `sess_end_i` pulse clears `session_o` on the next edge and so removes the VBUS supply enable in host role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_host_i | input | 1 | Role request from the mode register: 1 host, 0 device |
| sess_start_i | input | 1 | One-cycle pulse that requests a session |
| sess_end_i | input | 1 | One-cycle pulse that ends the session (wins over start) |
| phy_vbus_valid_i | input | 1 | Asynchronous VBUS-valid status from the PHY |
| vbus_drv_o | output | 1 | Enable for the external VBUS supply |
| dp_pullup_o | output | 1 | D+ pull-up enable |
| dp_pulldn_o | output | 1 | D+ pull-down enable |
| dm_pulldn_o | output | 1 | D- pull-down enable |
| session_o | output | 1 | Session-active flag |
| in_uses_tx_o | output | 1 | 1 when IN traffic is served by transmit endpoints |
| out_uses_tx_o | output | 1 | 1 when OUT traffic is served by transmit endpoints |

## Verification
The bench builds the block with DEB_LEN set to 4 and the default two-stage synchroniser. This keeps the debounce window short, so the exact arrival edge of a VBUS change, a glitch one cycle shorter than that window, and the clearing of a session on VBUS loss can all be checked directly at the ports. With the short window, the random phase also covers many VBUS edges that land close to role changes and session pulses, where the termination rules and the one-cycle gap are easiest to break.

// File: rtl/dualrole_pkg.sv
package dualrole_pkg;
  typedef enum logic {
    ROLE_DEV  = 1'b0,
    ROLE_HOST = 1'b1
  } role_e;

  typedef struct packed {
    logic vbus_drv;
    logic dp_pu;
    logic dp_pd;
    logic dm_pd;
  } term_t;

  localparam term_t TERM_OFF = '{vbus_drv: 1'b0, dp_pu: 1'b0, dp_pd: 1'b0, dm_pd: 1'b0};
endpackage

// File: rtl/vbus_filter.sv
module vbus_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic ok_o
);
  localparam int CW = $clog2(DEB_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   ok_q;
  logic                   synced;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= raw_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (synced == ok_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEB_LEN - 1)) begin
      cnt_q <= '0;
      ok_q  <= synced;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/role_sess_ctl.sv
module role_sess_ctl
  import dualrole_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  role_req_i,
  input  logic  start_i,
  input  logic  end_i,
  input  logic  vbus_ok_i,
  output role_e role_o,
  output logic  gap_o,
  output logic  sess_o
);
  role_e role_q;
  logic  gap_q;
  logic  sess_q;
  logic  switch_ok;
  logic  dev_lost;

  assign switch_ok = (role_e'(role_req_i) != role_q) && !sess_q && !gap_q;
  assign dev_lost  = (role_q == ROLE_DEV) && !vbus_ok_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      role_q <= ROLE_DEV;
      gap_q  <= 1'b0;
    end else begin
      gap_q <= switch_ok;
      if (switch_ok) role_q <= role_e'(role_req_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    sess_q <= 1'b0;
    else if (end_i || dev_lost) sess_q <= 1'b0;
    else if (start_i)           sess_q <= 1'b1;
  end

  assign role_o = role_q;
  assign gap_o  = gap_q;
  assign sess_o = sess_q;
endmodule

// File: rtl/pin_drive.sv
module pin_drive
  import dualrole_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  role_e role_i,
  input  logic  gap_i,
  input  logic  sess_i,
  input  logic  vbus_ok_i,
  output term_t term_o,
  output logic  in_tx_o,
  output logic  out_tx_o
);
  term_t term_d;
  term_t term_q;
  logic  in_tx_q;
  logic  out_tx_q;

  always_comb begin
    term_d = TERM_OFF;
    if (!gap_i) begin
      if (role_i == ROLE_HOST) begin
        term_d.vbus_drv = sess_i;
        term_d.dp_pd    = 1'b1;
        term_d.dm_pd    = 1'b1;
      end else begin
        term_d.dp_pu    = vbus_ok_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      term_q   <= TERM_OFF;
      in_tx_q  <= 1'b1;
      out_tx_q <= 1'b0;
    end else begin
      term_q   <= term_d;
      in_tx_q  <= (role_i == ROLE_DEV);
      out_tx_q <= (role_i == ROLE_HOST);
    end
  end

  assign term_o   = term_q;
  assign in_tx_o  = in_tx_q;
  assign out_tx_o = out_tx_q;
endmodule

// File: rtl/dualrole_pwr_ctl.sv
module dualrole_pwr_ctl
  import dualrole_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_LEN     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_host_i,
  input  logic sess_start_i,
  input  logic sess_end_i,
  input  logic phy_vbus_valid_i,
  output logic vbus_drv_o,
  output logic dp_pullup_o,
  output logic dp_pulldn_o,
  output logic dm_pulldn_o,
  output logic session_o,
  output logic in_uses_tx_o,
  output logic out_uses_tx_o
);
  logic  vbus_ok;
  role_e role_q;
  logic  gap_q;
  logic  sess_q;
  term_t term;

  vbus_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_LEN(DEB_LEN)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .raw_i (phy_vbus_valid_i),
    .ok_o  (vbus_ok)
  );

  role_sess_ctl u_role (
    .clk        (clk),
    .rst        (rst),
    .role_req_i (mode_host_i),
    .start_i    (sess_start_i),
    .end_i      (sess_end_i),
    .vbus_ok_i  (vbus_ok),
    .role_o     (role_q),
    .gap_o      (gap_q),
    .sess_o     (sess_q)
  );

  pin_drive u_pins (
    .clk       (clk),
    .rst       (rst),
    .role_i    (role_q),
    .gap_i     (gap_q),
    .sess_i    (sess_q),
    .vbus_ok_i (vbus_ok),
    .term_o    (term),
    .in_tx_o   (in_uses_tx_o),
    .out_tx_o  (out_uses_tx_o)
  );

  assign vbus_drv_o  = term.vbus_drv;
  assign dp_pullup_o = term.dp_pu;
  assign dp_pulldn_o = term.dp_pd;
  assign dm_pulldn_o = term.dm_pd;
  assign session_o   = sess_q;
endmodule

// File: rtl/dualrole_chk.sv
module dualrole_chk (
  input logic clk,
  input logic rst,
  input logic role_q,
  input logic sess_q,
  input logic vbus_ok,
  input logic vbus_drv_o,
  input logic dp_pullup_o,
  input logic dp_pulldn_o,
  input logic dm_pulldn_o,
  input logic in_uses_tx_o,
  input logic out_uses_tx_o
);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(dp_pullup_o && (dp_pulldn_o || dm_pulldn_o)));

  assert_gap_on_switch_R9: assert property (@(posedge clk) disable iff (rst)
    (in_uses_tx_o != $past(in_uses_tx_o)) |->
      !(vbus_drv_o || dp_pullup_o || dp_pulldn_o || dm_pulldn_o));

  assert_role_locked_R8: assert property (@(posedge clk) disable iff (rst)
    sess_q |=> (role_q == $past(role_q)));

  assert_pullup_needs_vbus_R5: assert property (@(posedge clk) disable iff (rst)
    dp_pullup_o |-> $past(vbus_ok));

  assert_map_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    in_uses_tx_o != out_uses_tx_o);

  assert_drv_host_only_R3: assert property (@(posedge clk) disable iff (rst)
    vbus_drv_o |-> (out_uses_tx_o && dp_pulldn_o && dm_pulldn_o));
endmodule

bind dualrole_pwr_ctl dualrole_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .role_q        (role_q),
  .sess_q        (sess_q),
  .vbus_ok       (vbus_ok),
  .vbus_drv_o    (vbus_drv_o),
  .dp_pullup_o   (dp_pullup_o),
  .dp_pulldn_o   (dp_pulldn_o),
  .dm_pulldn_o   (dm_pulldn_o),
  .in_uses_tx_o  (in_uses_tx_o),
  .out_uses_tx_o (out_uses_tx_o)
);

// File: tb/test_dualrole_pwr_ctl.sv
`timescale 1ns/1ps
module test_dualrole_pwr_ctl;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_host = 1'b0, s_start = 1'b0, s_end = 1'b0, vbus = 1'b0;
  logic drv, pu, pdp, pdm, sess, in_tx, out_tx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dualrole_pwr_ctl #(.SYNC_STAGES(2), .DEB_LEN(DEB)) i_dualrole_pwr_ctl (
    .clk(clk), .rst(rst), .mode_host_i(mode_host), .sess_start_i(s_start),
    .sess_end_i(s_end), .phy_vbus_valid_i(vbus), .vbus_drv_o(drv),
    .dp_pullup_o(pu), .dp_pulldn_o(pdp), .dm_pulldn_o(pdm), .session_o(sess),
    .in_uses_tx_o(in_tx), .out_uses_tx_o(out_tx)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pins();
    return {drv, pu, pdp, pdm};
  endfunction

  // Legal pin pattern for the mapping that is shown: device {drv,pu,pdp,pdm}
  // is 0x00 or 0100; host is 0000, 0011 or 1011.
  function automatic bit legal(input logic host_map, input int p);
    if (host_map) return (p == 4'b0000) || (p == 4'b0011) || (p == 4'b1011);
    return (p == 4'b0000) || (p == 4'b0100);
  endfunction

  task automatic pulse_start();
    s_start = 1'b1; tick(); s_start = 1'b0;
  endtask

  task automatic pulse_end();
    s_end = 1'b1; tick(); s_end = 1'b0;
  endtask

  initial begin
    bit glitch_ok;
    void'($urandom(32'd1234));
    tick(3);
    rst = 1'b0;
    // R1: reset values
    check("R1 pins", pins(), 0);
    check("R1 session", sess, 0);
    check("R1 in_uses_tx", in_tx, 1);
    check("R10 out_uses_tx after reset", out_tx, 0);

    // R6/R5: VBUS rise reaches pull-up exactly DEB+3 edges later
    vbus = 1'b1;
    tick(DEB + 2);
    check("R6 pull-up not yet", pu, 0);
    tick();
    check("R5 pull-up with VBUS", pu, 1);
    check("R3 device pins", {drv, pdp, pdm}, 0);

    // R6: short low glitch is filtered
    vbus = 1'b0; tick(DEB - 1); vbus = 1'b1;
    glitch_ok = 1'b1;
    for (int i = 0; i < 3 * DEB; i++) begin
      tick();
      if (pu !== 1'b1) glitch_ok = 1'b0;
    end
    check("R6 glitch filtered", glitch_ok, 1);

    // R7: VBUS loss ends device session and removes pull-up
    pulse_start();
    check("R7 session started", sess, 1);
    vbus = 1'b0;
    tick(DEB + 2);
    check("R7 pull-up held", pu, 1);
    tick();
    check("R7 pull-up removed", pu, 0);
    check("R7 session cleared", sess, 0);
    pulse_start();
    tick();
    check("R7 start ignored w/o VBUS", sess, 0);

    // R9/R10/R4: device to host
    mode_host = 1'b1;
    tick(2);
    check("R9 gap pins", pins(), 0);
    check("R10 host out_uses_tx", out_tx, 1);
    check("R10 host in_uses_tx", in_tx, 0);
    tick();
    check("R4 host pins no session", pins(), 4'b0011);

    // R2: session in host drives VBUS
    pulse_start();
    check("R2 session on", sess, 1);
    tick();
    check("R2 vbus drive", drv, 1);

    // R8: role change ignored while session active
    mode_host = 1'b0;
    tick(5);
    check("R8 role held", out_tx, 1);
    check("R8 pins held", pins(), 4'b1011);

    // R11: end session, then pending role change applies
    pulse_end();
    check("R11 session cleared", sess, 0);
    tick();
    check("R11 vbus drive off", drv, 0);
    tick();
    check("R9 gap pins back", pins(), 0);
    check("R8 role applied", in_tx, 1);
    tick();
    check("R3 device pins no VBUS", pins(), 0);

    // Random phase: pin patterns must fit the shown mapping (R2-R5, R9, R10)
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 9) == 0) vbus = ~vbus;
      if ($urandom_range(0, 29) == 0) mode_host = ~mode_host;
      s_start = ($urandom_range(0, 7) == 0);
      s_end   = ($urandom_range(0, 19) == 0);
      tick();
      check("R10 mapping exclusive", in_tx ^ out_tx, 1);
      check("R9 legal pins for role", legal(out_tx, pins()), 1);
    end
    s_start = 1'b0; s_end = 1'b0;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule